// File: doc/BRIEF.md
# Parallel Blind Phase Search Recovery

This block removes the leftover carrier phase from blocks of symbols that are already in polar form (amplitude and phase) and already corrected in frequency. Each clock cycle it takes one block of `LANES` symbols. It makes `NTEST` rotated copies of the block's phases, each copy using a different trial rotation, and scores every copy at once. A copy's score is the block-mean distance between each rotated phase and the nearest reference angle that the symbol's constellation ring allows. The rotation with the lowest score is then added to every phase of the original block. The block uses adders, comparators and shifts only.

The modulation format can change from one block to the next. For the square formats the reference angles sit on the diagonals. The 8-point format uses amplitude to separate an inner ring on the axes from an outer ring on the diagonals. The 16-point format uses amplitude to find its middle ring. Symbols on that ring then take a second decision on phase, which picks one of two references inside the quarter-turn. Outside the ring classification, every step works on phase alone. The pipeline has a fixed latency, and a valid flag travels along with each block.

Top module: `phase_search_rec`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `out_valid` is 0. Right after reset, `out_phase` and `out_idx` read 0.
- R2: `out_valid` repeats `in_valid` exactly three clock edges later. An idle input cycle gives an idle output cycle.
- R3: Trial rotation k is floor(k*64/NTEST) phase codes, for k = 0..NTEST-1. Every output phase is the input phase plus the rotation of the chosen index `out_idx`, taken modulo 256.
- R4: Format code 0 (4-point) uses reference phases 32+64m. A symbol's distance is |r-32|, where r is the rotated phase modulo 64. A trial's cost is the sum of the lane distances shifted right by log2(LANES). The chosen index is the one with the lowest cost.
- R5: Format code 1 (8-point) treats a symbol with amplitude below THR8 (default 96) as an inner-ring symbol, with references 64m and distance min(r, 64-r). It treats all other symbols like R4.
- R6: Format code 2 (16-point) treats amplitudes in [THR16_LO, THR16_HI) (default 70 to 111) as the middle ring. For such a symbol, r < 32 is scored against 13 and r >= 32 against 51. Amplitudes outside that range are scored like R4.
- R7: When several trials share the lowest cost, the lowest index is chosen.
- R8: The format is taken per block, so back-to-back blocks with different formats are each handled by their own format. Format code 3 behaves as code 0.
- R9: Phase arithmetic wraps modulo 256, both in the trial rotation and in the correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block is valid |
| in_fmt | input | 2 | Format: 0 4-point, 1 8-point, 2 16-point, 3 as 0 |
| in_amp | input | LANES*AMP_W | Amplitude per lane, lane 0 in the low bits |
| in_phase | input | LANES*8 | Phase per lane, 256 codes per turn, lane 0 in the low bits |
| out_valid | output | 1 | Output block is valid |
| out_phase | output | LANES*8 | Corrected phases |
| out_idx | output | IDX_W | Index of the chosen trial rotation |

## Verification
The hardest cases to reach from the ports are a true tie in the averaged cost and the middle-ring phase decision. Noisy input would hide both. The stimulus therefore builds exact constellation blocks, rotated back by a known trial angle, so the correct index gives a cost of exactly zero. It also builds constant-phase blocks that sit exactly halfway between two neighbouring trials, so those two costs are equal and the tie rule decides. Back-to-back blocks of three different formats, with a trailing idle cycle, exercise the per-block format switch and the travel of the valid flag.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PHASE_W  = 8;
  localparam int SECT     = 1 << (PHASE_W - 2);
  localparam int HALF     = SECT / 2;
  localparam int MID_NEAR = (SECT * 205 + 500) / 1000;
  localparam int MID_FAR  = SECT - MID_NEAR;
  localparam int DIST_W   = PHASE_W - 2;

  typedef enum logic [1:0] {FMT_4Q = 2'd0, FMT_8Q = 2'd1, FMT_16Q = 2'd2, FMT_SPARE = 2'd3} fmt_e;
  typedef enum logic [1:0] {RING_DIAG = 2'd0, RING_AXIS = 2'd1, RING_MID = 2'd2} ring_e;

  function automatic logic [PHASE_W-1:0] test_phase(input int k, input int n);
    return PHASE_W'((k * SECT) / n);
  endfunction

  function automatic logic [DIST_W-1:0] ring_dist(input ring_e cls, input logic [PHASE_W-1:0] q);
    int r;
    int d;
    r = int'(q) % SECT;
    case (cls)
      RING_AXIS: d = (r < HALF) ? r : SECT - r;
      RING_MID: begin
        if (r < HALF) d = (r >= MID_NEAR) ? r - MID_NEAR : MID_NEAR - r;
        else          d = (r >= MID_FAR)  ? r - MID_FAR  : MID_FAR - r;
      end
      default:   d = (r < HALF) ? HALF - r : r - HALF;
    endcase
    return DIST_W'(d);
  endfunction
endpackage

// File: rtl/psr_ring_class.sv
module psr_ring_class import psr_pkg::*; #(
  parameter int AMP_W    = 8,
  parameter int THR8     = 96,
  parameter int THR16_LO = 70,
  parameter int THR16_HI = 112
) (
  input  logic [1:0]       fmt,
  input  logic [AMP_W-1:0] amp,
  output logic [1:0]       cls
);
  localparam logic [AMP_W-1:0] T8 = AMP_W'(THR8);
  localparam logic [AMP_W-1:0] TL = AMP_W'(THR16_LO);
  localparam logic [AMP_W-1:0] TH = AMP_W'(THR16_HI);

  always_comb begin
    case (fmt_e'(fmt))
      FMT_8Q:  cls = (amp < T8) ? RING_AXIS : RING_DIAG;
      FMT_16Q: cls = (amp >= TL && amp < TH) ? RING_MID : RING_DIAG;
      default: cls = RING_DIAG;
    endcase
  end
endmodule

// File: rtl/psr_cost.sv
module psr_cost import psr_pkg::*; #(
  parameter int LANES = 32,
  parameter logic [PHASE_W-1:0] OFFSET = '0
) (
  input  logic [2*LANES-1:0]       cls_flat,
  input  logic [LANES*PHASE_W-1:0] phase,
  output logic [DIST_W-1:0]        cost
);
  localparam int LG    = $clog2(LANES);
  localparam int SUM_W = DIST_W + LG + 1;

  logic [SUM_W-1:0]   acc;
  logic [PHASE_W-1:0] q;

  always_comb begin
    acc = '0;
    q   = '0;
    for (int i = 0; i < LANES; i++) begin
      q   = phase[i*PHASE_W +: PHASE_W] + OFFSET;
      acc = acc + SUM_W'(ring_dist(ring_e'(cls_flat[2*i +: 2]), q));
    end
    cost = DIST_W'(acc >> LG);
  end
endmodule

// File: rtl/psr_argmin.sv
module psr_argmin #(
  parameter int N  = 24,
  parameter int W  = 6,
  parameter int IW = 5
) (
  input  logic [N*W-1:0] costs,
  output logic [IW-1:0]  idx
);
  logic [W-1:0] best;

  always_comb begin
    best = costs[0 +: W];
    idx  = '0;
    for (int t = 1; t < N; t++) begin
      if (costs[t*W +: W] < best) begin
        best = costs[t*W +: W];
        idx  = IW'(t);
      end
    end
  end
endmodule

// File: rtl/phase_search_rec.sv
module phase_search_rec import psr_pkg::*; #(
  parameter int LANES    = 32,
  parameter int NTEST    = 24,
  parameter int AMP_W    = 8,
  parameter int THR8     = 96,
  parameter int THR16_LO = 70,
  parameter int THR16_HI = 112,
  localparam int IDX_W   = $clog2(NTEST)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [1:0]               in_fmt,
  input  logic [LANES*AMP_W-1:0]   in_amp,
  input  logic [LANES*PHASE_W-1:0] in_phase,
  output logic                     out_valid,
  output logic [LANES*PHASE_W-1:0] out_phase,
  output logic [IDX_W-1:0]         out_idx
);
  localparam int PH_BITS = LANES * PHASE_W;

  logic [2*LANES-1:0]      cls_flat;
  logic [NTEST*DIST_W-1:0] cost_d, cost_q;
  logic                    s1_valid, s2_valid;
  logic [PH_BITS-1:0]      s1_phase, s2_phase;
  logic [IDX_W-1:0]        min_idx, s2_idx;
  logic [PHASE_W-1:0]      corr;

  // ring classes, shared by every trial rotation
  for (genvar g = 0; g < LANES; g++) begin : g_cls
    psr_ring_class #(
      .AMP_W(AMP_W), .THR8(THR8), .THR16_LO(THR16_LO), .THR16_HI(THR16_HI)
    ) u_cls (
      .fmt(in_fmt),
      .amp(in_amp[g*AMP_W +: AMP_W]),
      .cls(cls_flat[2*g +: 2])
    );
  end

  // one cost unit per trial rotation, all concurrent
  for (genvar t = 0; t < NTEST; t++) begin : g_cost
    psr_cost #(.LANES(LANES), .OFFSET(test_phase(t, NTEST))) u_cost (
      .cls_flat(cls_flat),
      .phase(in_phase),
      .cost(cost_d[t*DIST_W +: DIST_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_phase <= '0;
      cost_q   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_phase <= in_phase;
      cost_q   <= cost_d;
    end
  end

  psr_argmin #(.N(NTEST), .W(DIST_W), .IW(IDX_W)) u_min (
    .costs(cost_q),
    .idx(min_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_phase <= '0;
      s2_idx   <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_phase <= s1_phase;
      s2_idx   <= min_idx;
    end
  end

  always_comb begin
    corr = '0;
    for (int t = 0; t < NTEST; t++)
      if (s2_idx == IDX_W'(t)) corr = test_phase(t, NTEST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_phase <= '0;
      out_idx   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_idx   <= s2_idx;
      for (int i = 0; i < LANES; i++)
        out_phase[i*PHASE_W +: PHASE_W] <= s2_phase[i*PHASE_W +: PHASE_W] + corr;
    end
  end
endmodule

// File: rtl/psr_check.sv
module psr_check import psr_pkg::*; #(
  parameter int NTEST = 24,
  parameter int IDX_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [PHASE_W-1:0] in_ph0,
  input logic               out_valid,
  input logic [PHASE_W-1:0] out_ph0,
  input logic [IDX_W-1:0]   out_idx
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_correction_lane0: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && out_valid) |->
      (out_ph0 == PHASE_W'($past(in_ph0, 3) + test_phase(int'(out_idx), NTEST))));

  a_r7_index_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_idx) < NTEST));
endmodule

bind phase_search_rec psr_check #(.NTEST(NTEST), .IDX_W(IDX_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .in_valid(in_valid),
  .in_ph0(in_phase[psr_pkg::PHASE_W-1:0]),
  .out_valid(out_valid),
  .out_ph0(out_phase[psr_pkg::PHASE_W-1:0]),
  .out_idx(out_idx)
);

// File: tb/phase_search_rec_tb.sv
module phase_search_rec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int NT = 24;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_fmt = '0;
  logic [L*8-1:0] in_amp = '0;
  logic [L*8-1:0] in_phase = '0;
  logic          out_valid;
  logic [L*8-1:0] out_phase;
  logic [IW-1:0] out_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] s_in  [3][L];
  logic [7:0] s_amp [3][L];
  logic [7:0] s_exp [3][L];
  logic [1:0] s_fmt [3];
  int         s_idx [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_search_rec u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_amp(in_amp), .in_phase(in_phase),
    .out_valid(out_valid), .out_phase(out_phase), .out_idx(out_idx)
  );

  function automatic int tp(input int k);
    return (k * 64) / NT;
  endfunction

  task automatic report(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kind: 0 diag 4-point, 1 8-point mix, 2 16-point mix, 3 16-point middle only,
  //       4 tie at phase 31, 5 tie at phase 23
  task automatic build(input int slot, input int kind, input int k, input logic [1:0] fmt);
    int base;
    int a;
    s_fmt[slot] = fmt;
    s_idx[slot] = k;
    for (int i = 0; i < L; i++) begin
      a = 96;
      case (kind)
        0: base = 32 + 64 * (i % 4);
        1: begin
          if (i % 2 == 0) begin base = 64 * ((i / 2) % 4); a = 40; end
          else begin base = 32 + 64 * ((i / 2) % 4); a = 120; end
        end
        2: begin
          if (i % 3 == 0) begin base = 32 + 64 * (i % 4); a = 40; end
          else if (i % 3 == 1) begin base = 32 + 64 * (i % 4); a = 130; end
          else base = (((i / 3) % 2) != 0 ? 51 : 13) + 64 * (i % 4);
        end
        3: base = ((i % 2) != 0 ? 51 : 13) + 64 * ((i / 2) % 4);
        default: base = 0;
      endcase
      if (kind >= 4) begin
        s_in[slot][i]  = (kind == 4) ? 8'd31 : 8'd23;
        s_exp[slot][i] = 8'd31;
      end else begin
        s_in[slot][i]  = 8'((base - tp(k)) & 255);
        s_exp[slot][i] = 8'(base & 255);
      end
      s_amp[slot][i] = 8'(a);
    end
  endtask

  task automatic apply(input int slot);
    in_fmt = s_fmt[slot];
    for (int i = 0; i < L; i++) begin
      in_phase[i*8 +: 8] = s_in[slot][i];
      in_amp[i*8 +: 8]   = s_amp[slot][i];
    end
    in_valid = 1'b1;
  endtask

  task automatic check_slot(input int slot, input string req);
    int bad;
    int first;
    bad = 0;
    first = 0;
    report(out_valid === 1'b1, req, "out_valid", int'(out_valid), 1);
    report(int'(out_idx) == s_idx[slot], req, "out_idx", int'(out_idx), s_idx[slot]);
    for (int i = L - 1; i >= 0; i--)
      if (out_phase[i*8 +: 8] !== s_exp[slot][i]) begin bad++; first = i; end
    report(bad == 0, {req, "/R3"}, "out_phase lane",
           int'(out_phase[first*8 +: 8]), int'(s_exp[slot][first]));
  endtask

  task automatic run_single(input int slot, input string req);
    @(negedge clk); apply(slot);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); check_slot(slot, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    build(0, 0, 5, 2'd0);
    @(negedge clk); apply(0);
    repeat (4) @(negedge clk);
    report(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    report(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    report(out_phase === '0, "R1", "out_phase after reset", int'(out_phase[7:0]), 0);
    report(out_idx === '0, "R1", "out_idx after reset", int'(out_idx), 0);
  endtask

  task automatic t_four_point;
    build(0, 0, 5, 2'd0);  run_single(0, "R4");
    build(0, 0, 0, 2'd0);  run_single(0, "R4");
    build(0, 0, 11, 2'd3); run_single(0, "R8 code3");
  endtask

  task automatic t_wrap;
    build(0, 0, 23, 2'd0); run_single(0, "R9");
  endtask

  task automatic t_eight_point;
    build(0, 1, 17, 2'd1); run_single(0, "R5");
  endtask

  task automatic t_sixteen_point;
    build(0, 2, 9, 2'd2);  run_single(0, "R6 mix");
    build(0, 3, 0, 2'd2);  run_single(0, "R6 middle");
    build(0, 3, 14, 2'd2); run_single(0, "R6 middle rot");
  endtask

  task automatic t_tie;
    build(0, 4, 0, 2'd0); run_single(0, "R7 tie01");
    build(0, 5, 3, 2'd0); run_single(0, "R7 tie34");
  endtask

  task automatic t_stream;
    build(0, 0, 5, 2'd0);
    build(1, 1, 17, 2'd1);
    build(2, 2, 9, 2'd2);
    @(negedge clk); apply(0);
    @(negedge clk); apply(1);
    @(negedge clk); apply(2);
    @(negedge clk); in_valid = 1'b0; check_slot(0, "R8 s0");
    @(negedge clk); check_slot(1, "R8 s1");
    @(negedge clk); check_slot(2, "R8 s2");
    @(negedge clk);
    report(out_valid === 1'b0, "R2", "bubble after stream", int'(out_valid), 0);
  endtask

  task automatic t_latency;
    build(0, 0, 2, 2'd0);
    @(negedge clk); apply(0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    report(out_valid === 1'b0, "R2", "out_valid at edge 2", int'(out_valid), 0);
    @(negedge clk);
    report(out_valid === 1'b1, "R2", "out_valid at edge 3", int'(out_valid), 1);
    @(negedge clk);
    report(out_valid === 1'b0, "R2", "out_valid at edge 4", int'(out_valid), 0);
  endtask

  initial begin
    t_reset;
    t_four_point;
    t_wrap;
    t_eight_point;
    t_sixteen_point;
    t_tie;
    t_stream;
    t_latency;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule